// File: doc/BRIEF.md
# Double-Buffered Video Serializer

This block turns 32-bit image words into one serial video bit stream for a raster imaging engine, such as a laser marking engine. Software or a DMA engine writes each word into a holding register in the system clock domain. Words then move into a shift register that runs on a separate shift clock. That clock may be asynchronous to the system clock, or it may be the same net. Because the holding register backs up the shift register, the writer has one whole word time to supply the next word.

A programmable divider turns the shift clock into a pixel strobe. A page begins on a rising edge of the external page-sync input. The page starts with a number of blank lines. Each line then starts with a number of blank pixels, followed by its active pixels. Once the last active line has been sent, the block goes idle until the next page sync. While the holding register is empty, the block raises either an interrupt request or a DMA request, chosen by a control bit. Two sticky status bits record a word that was missing when it was needed (underrun) and a write that was refused (overrun).

Register map (write port and read port, 3-bit address):

| Address | Contents |
|---|---|
| 0 | Image word |
| 1 | Control: bit 0 = enable, bit 1 = interrupt enable, bit 2 = DMA mode |
| 2 | Divider N |
| 3 | Left blank pixels (HB) |
| 4 | Top blank lines (VB) |
| 5 | Active pixels per line (LP) |
| 6 | Active lines per page (PL) |
| 7 | Status: bit 0 = holding full, bit 1 = underrun, bit 2 = overrun. Bits 1 and 2 clear when written with 1. |

Top module: `vser_top`

## Requirements
- R1: After reset, `video_o`, `pix_stb_o`, `irq_o` and `dma_req_o` are 0 and the status register reads 0.
- R2: A write to address 0 while the holding register is empty stores the word and sets status bit 0. A write to address 0 while it is full is ignored, and the word already held is kept. Such a write sets the sticky status bit 2, which clears only when bit 2 is written with 1 to address 7.
- R3: `irq_o` = interrupt enable AND NOT DMA mode AND holding empty. `dma_req_o` = DMA mode AND enable AND holding empty. The two are never high together.
- R4: During a page, `pix_stb_o` pulses once every N+1 shift clock edges, where N is the divider value.
- R5: A page starts only on a rising edge of `page_sync` while enable is 1 and the block is idle. A page gives exactly (VB+PL)*(HB+LP) strobes and then no more until the next page sync.
- R6: `video_o` is 0 on every strobe of the VB blank lines and on the first HB strobes of every line.
- R7: Active pixels carry the written words most significant bit first, in write order. Consecutive words follow with no gap, provided each word is written before the previous one has finished shifting.
- R8: If a word is needed at an active pixel while the holding register is empty, that pixel is 0, status bit 1 is set and stays set until bit 1 is written with 1, and the strobe and line counting continue unchanged.
- R9: With the shift clock tied to the system clock, R4 to R7 hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| vclk | input | 1 | Shift clock, asynchronous or tied to clk |
| page_sync | input | 1 | Page-start pulse, asynchronous |
| video_o | output | 1 | Serial video bit (vclk domain) |
| pix_stb_o | output | 1 | One-vclk pulse marking each new video bit |
| irq_o | output | 1 | Holding-empty interrupt request |
| dma_req_o | output | 1 | Holding-empty DMA request |

## Verification
The assertions assume that LP and PL are at least 1. They also assume that the geometry, divider and enable registers change only while the block is idle. Finally, they assume that a `page_sync` pulse is wider than two shift clock periods. The bench follows these assumptions: it programs every register and then pulses page sync for four shift clocks. It also waits for each page to finish before it writes the registers again. Random geometries use LP values that are multiples of 8 and PL values of 4 or 8, so each page holds a whole number of words. The divider stays small, so the bench can refill the holding register in time.

// File: rtl/vser_pkg.sv
`timescale 1ns/1ps
package vser_pkg;
    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_CTRL = 3'd1,
        A_DIV  = 3'd2,
        A_HBLK = 3'd3,
        A_VBLK = 3'd4,
        A_LPIX = 3'd5,
        A_PLIN = 3'd6,
        A_STAT = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_VBLANK = 2'd1,
        RS_ACTIVE = 2'd2
    } rstate_e;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_IRQ = 1;
    localparam int CTRL_DMA = 2;
    localparam int ST_FULL  = 0;
    localparam int ST_UND   = 1;
    localparam int ST_OVR   = 2;
endpackage

// File: rtl/vser_sync.sv
`timescale 1ns/1ps
module vser_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/vser_host.sv
`timescale 1ns/1ps
module vser_host
    import vser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [2:0]        waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [2:0]        raddr_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic              take_tog_i,
    input  logic              und_flag_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              wr_tog_o,
    output logic              en_o,
    output logic [CNT_W-1:0]  div_o,
    output logic [CNT_W-1:0]  hb_o,
    output logic [CNT_W-1:0]  vb_o,
    output logic [CNT_W-1:0]  lp_o,
    output logic [CNT_W-1:0]  pl_o,
    output logic              irq_o,
    output logic              dma_o
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              wr_tog;
        logic              en;
        logic              irq_en;
        logic              dma;
        logic              und;
        logic              und_prev;
        logic              ovr;
        logic [CNT_W-1:0]  div;
        logic [CNT_W-1:0]  hb;
        logic [CNT_W-1:0]  vb;
        logic [CNT_W-1:0]  lp;
        logic [CNT_W-1:0]  pl;
    } host_t;

    host_t q, d;
    logic  take_s, und_s, full, und_rise;

    vser_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({take_tog_i, und_flag_i}),
        .q_o  ({take_s, und_s})
    );

    // one word in flight: full while the write toggle leads the take toggle
    assign full     = q.wr_tog ^ take_s;
    assign und_rise = und_s & ~q.und_prev;

    always_comb begin
        d          = q;
        d.und_prev = und_s;
        if (we_i) begin
            case (reg_addr_e'(waddr_i))
                A_DATA: begin
                    if (full) begin
                        d.ovr = 1'b1;
                    end else begin
                        d.hold   = wdata_i;
                        d.wr_tog = ~q.wr_tog;
                    end
                end
                A_CTRL: begin
                    d.en     = wdata_i[CTRL_EN];
                    d.irq_en = wdata_i[CTRL_IRQ];
                    d.dma    = wdata_i[CTRL_DMA];
                end
                A_DIV:  d.div = wdata_i[CNT_W-1:0];
                A_HBLK: d.hb  = wdata_i[CNT_W-1:0];
                A_VBLK: d.vb  = wdata_i[CNT_W-1:0];
                A_LPIX: d.lp  = wdata_i[CNT_W-1:0];
                A_PLIN: d.pl  = wdata_i[CNT_W-1:0];
                A_STAT: begin
                    if (wdata_i[ST_UND]) d.und = 1'b0;
                    if (wdata_i[ST_OVR]) d.ovr = 1'b0;
                end
                default: ;
            endcase
        end
        if (und_rise) d.und = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr_e'(raddr_i))
            A_DATA:  rdata_o = q.hold;
            A_CTRL:  rdata_o = WORD_W'({q.dma, q.irq_en, q.en});
            A_DIV:   rdata_o = WORD_W'(q.div);
            A_HBLK:  rdata_o = WORD_W'(q.hb);
            A_VBLK:  rdata_o = WORD_W'(q.vb);
            A_LPIX:  rdata_o = WORD_W'(q.lp);
            A_PLIN:  rdata_o = WORD_W'(q.pl);
            A_STAT:  rdata_o = WORD_W'({q.ovr, q.und, full});
            default: rdata_o = '0;
        endcase
    end

    assign hold_o   = q.hold;
    assign wr_tog_o = q.wr_tog;
    assign en_o     = q.en;
    assign div_o    = q.div;
    assign hb_o     = q.hb;
    assign vb_o     = q.vb;
    assign lp_o     = q.lp;
    assign pl_o     = q.pl;
    assign irq_o    = q.irq_en & ~q.dma & ~full;
    assign dma_o    = q.dma & q.en & ~full;

    // R2
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == A_DATA && full) |=> ($stable(q.hold) && q.ovr));
    // R3
    req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !(irq_o || dma_o));
    // R3
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && dma_o));
endmodule

// File: rtl/vser_raster.sv
`timescale 1ns/1ps
module vser_raster
    import vser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              vclk,
    input  logic              rst_n,
    input  logic              page_sync_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  div_i,
    input  logic [CNT_W-1:0]  hb_i,
    input  logic [CNT_W-1:0]  vb_i,
    input  logic [CNT_W-1:0]  lp_i,
    input  logic [CNT_W-1:0]  pl_i,
    input  logic [WORD_W-1:0] hold_i,
    input  logic              wr_tog_i,
    output logic              take_tog_o,
    output logic              und_flag_o,
    output logic              video_o,
    output logic              stb_o
);
    localparam int LEFT_W = $clog2(WORD_W);

    typedef struct packed {
        rstate_e           state;
        logic [CNT_W-1:0]  dcnt;
        logic [CNT_W:0]    col;
        logic [CNT_W-1:0]  row;
        logic [WORD_W-1:0] sh;
        logic [LEFT_W-1:0] left;
        logic              take_tog;
        logic              und;
        logic              ps_prev;
        logic              video;
        logic              stb;
    } rast_t;

    rast_t          q, d;
    logic           wr_s, ps_s, tick, avail, line_last, pix;
    logic [CNT_W:0] line_len;

    vser_sync #(.W(2)) u_sync (
        .clk  (vclk),
        .rst_n(rst_n),
        .d_i  ({wr_tog_i, page_sync_i}),
        .q_o  ({wr_s, ps_s})
    );

    assign line_len  = {1'b0, hb_i} + {1'b0, lp_i};
    assign tick      = (q.dcnt == div_i);
    assign avail     = wr_s ^ q.take_tog;
    assign line_last = (q.col == line_len - 1'b1);
    assign pix       = (q.state == RS_ACTIVE) && (q.col >= {1'b0, hb_i});

    always_comb begin
        d         = q;
        d.stb     = 1'b0;
        d.ps_prev = ps_s;
        d.dcnt    = tick ? '0 : q.dcnt + 1'b1;
        case (q.state)
            RS_IDLE: begin
                if (tick) d.video = 1'b0;
                if (en_i && ps_s && !q.ps_prev) begin
                    d.state = (vb_i == '0) ? RS_ACTIVE : RS_VBLANK;
                    d.col   = '0;
                    d.row   = '0;
                    d.left  = '0;
                    d.und   = 1'b0;
                    d.dcnt  = '0;
                end
            end
            default: begin
                if (tick) begin
                    d.stb = 1'b1;
                    // pixel value: reload from holding at the edge the bit is due
                    if (!pix) begin
                        d.video = 1'b0;
                    end else if (q.left != '0) begin
                        d.video = q.sh[WORD_W-1];
                        d.sh    = {q.sh[WORD_W-2:0], 1'b0};
                        d.left  = q.left - 1'b1;
                    end else if (avail) begin
                        d.video    = hold_i[WORD_W-1];
                        d.sh       = {hold_i[WORD_W-2:0], 1'b0};
                        d.left     = LEFT_W'(WORD_W - 1);
                        d.take_tog = ~q.take_tog;
                    end else begin
                        d.video = 1'b0;
                        d.und   = 1'b1;
                    end
                    // raster position
                    if (!line_last) begin
                        d.col = q.col + 1'b1;
                    end else begin
                        d.col = '0;
                        d.row = q.row + 1'b1;
                        if (q.state == RS_VBLANK && q.row == vb_i - 1'b1) begin
                            d.state = RS_ACTIVE;
                            d.row   = '0;
                        end else if (q.state == RS_ACTIVE && q.row == pl_i - 1'b1) begin
                            d.state = RS_IDLE;
                            d.row   = '0;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge vclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign take_tog_o = q.take_tog;
    assign und_flag_o = q.und;
    assign video_o    = q.video;
    assign stb_o      = q.stb;

    // R4
    stb_spacing_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (q.stb && div_i != '0) |=> !q.stb);
    // R5
    idle_quiet_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (q.state == RS_IDLE) |=> !q.stb);
    // R6
    vblank_zero_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (q.state == RS_VBLANK && tick) |=> !video_o);
    // R6
    hblank_zero_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (q.state == RS_ACTIVE && tick && q.col < {1'b0, hb_i}) |=> !video_o);
    // R7
    reload_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (tick && pix && q.left == '0 && avail) |=> (q.left == LEFT_W'(WORD_W - 1)));
    // R8
    underrun_chk: assert property (@(posedge vclk) disable iff (!rst_n)
        (tick && pix && q.left == '0 && !avail) |=> (q.und && !video_o && q.stb));
endmodule

// File: rtl/vser_top.sv
`timescale 1ns/1ps
module vser_top #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              vclk,
    input  logic              page_sync,
    output logic              video_o,
    output logic              pix_stb_o,
    output logic              irq_o,
    output logic              dma_req_o
);
    logic [WORD_W-1:0] hold;
    logic              wr_tog, take_tog, und_flag, en;
    logic [CNT_W-1:0]  div, hb, vb, lp, pl;

    vser_host #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we),
        .waddr_i   (reg_waddr),
        .wdata_i   (reg_wdata),
        .raddr_i   (reg_raddr),
        .rdata_o   (reg_rdata),
        .take_tog_i(take_tog),
        .und_flag_i(und_flag),
        .hold_o    (hold),
        .wr_tog_o  (wr_tog),
        .en_o      (en),
        .div_o     (div),
        .hb_o      (hb),
        .vb_o      (vb),
        .lp_o      (lp),
        .pl_o      (pl),
        .irq_o     (irq_o),
        .dma_o     (dma_req_o)
    );

    vser_raster #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_raster (
        .vclk       (vclk),
        .rst_n      (rst_n),
        .page_sync_i(page_sync),
        .en_i       (en),
        .div_i      (div),
        .hb_i       (hb),
        .vb_i       (vb),
        .lp_i       (lp),
        .pl_i       (pl),
        .hold_i     (hold),
        .wr_tog_i   (wr_tog),
        .take_tog_o (take_tog),
        .und_flag_o (und_flag),
        .video_o    (video_o),
        .stb_o      (pix_stb_o)
    );
endmodule

// File: tb/vser_top_tb_top.sv
`timescale 1ns/1ps
module vser_top_tb_top;
    logic        clk = 1'b0, vfree = 1'b0, tie = 1'b0, rst_n = 1'b0;
    logic        we = 1'b0, psync = 1'b0;
    logic [2:0]  waddr = '0, raddr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        vclk, video, stb, irq, dma;

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] words [0:15];
    int          nw = 0;
    logic        cap [0:8191];
    int          cap_n = 0, gcnt = 0, gmin = 0, gmax = 0;
    logic        gap_rst = 1'b0;

    always #4 clk = ~clk;
    always #5.5 vfree = ~vfree;
    assign vclk = tie ? clk : vfree;

    vser_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
        .reg_raddr(raddr), .reg_rdata(rdata), .vclk(vclk), .page_sync(psync),
        .video_o(video), .pix_stb_o(stb), .irq_o(irq), .dma_req_o(dma)
    );

    always @(negedge vclk) begin
        if (gap_rst) begin
            gcnt = 0; gmin = 1 << 20; gmax = 0;
        end else if (stb) begin
            if (gcnt != 0) begin
                if (gcnt < gmin) gmin = gcnt;
                if (gcnt > gmax) gmax = gcnt;
            end
            gcnt = 1;
            if (cap_n < 8192) cap[cap_n] = video;
            cap_n = cap_n + 1;
        end else if (gcnt != 0) begin
            gcnt = gcnt + 1;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk); we = 1'b1; waddr = a; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); raddr = a; #1 v = rdata;
    endtask

    function automatic logic exp_bit(int idx, int hb, int vb, int lp);
        int ll = hb + lp;
        int ln = idx / ll;
        int cl = idx % ll;
        int a, w;
        if (ln < vb || cl < hb) return 1'b0;
        a = (ln - vb) * lp + (cl - hb);
        w = a / 32;
        if (w >= nw) return 1'b0;
        return words[w][31 - (a % 32)];
    endfunction

    task automatic set_geom(int hb, int vb, int lp, int pl, int dv, logic [31:0] ctrl);
        wr(3'd3, hb); wr(3'd4, vb); wr(3'd5, lp); wr(3'd6, pl); wr(3'd2, dv); wr(3'd1, ctrl);
    endtask

    task automatic run_page(input string tg, int hb, int vb, int lp, int pl, int dv,
                            int feed, int prewritten, output int errs);
        int base, total, k, guard, mm, am;
        logic [31:0] st;
        set_geom(hb, vb, lp, pl, dv, 32'h1);
        @(negedge vclk); gap_rst = 1'b1; @(negedge vclk); gap_rst = 1'b0;
        base  = cap_n;
        total = (vb + pl) * (hb + lp);
        k = prewritten;
        if (feed != 0 && k == 0 && nw > 0) begin wr(3'd0, words[0]); k = 1; end
        repeat (3) @(negedge vclk);
        psync = 1'b1; repeat (4) @(negedge vclk); psync = 1'b0;
        guard = 0;
        while ((cap_n - base) < total && guard < 30000) begin
            guard = guard + 1;
            if (feed != 0 && k < nw) begin
                rd(3'd7, st);
                if (st[0] == 1'b0) begin wr(3'd0, words[k]); k = k + 1; end
            end else begin
                @(negedge clk);
            end
        end
        repeat (40) @(negedge vclk);
        chk({"R5 strobe count ", tg}, cap_n - base, total);
        mm = 0; am = 0;
        for (int i = 0; i < total; i++) begin
            if (cap[base + i] !== exp_bit(i, hb, vb, lp)) begin
                if ((i / (hb + lp)) < vb || (i % (hb + lp)) < hb) mm = mm + 1;
                else am = am + 1;
            end
        end
        chk({"R6 blank bits ", tg}, mm, 0);
        chk({"R7 active bits ", tg}, am, 0);
        if (total > 1) begin
            chk({"R4 min spacing ", tg}, gmin, dv + 1);
            chk({"R4 max spacing ", tg}, gmax, dv + 1);
        end
        errs = mm + am + ((cap_n - base) != total ? 1 : 0);
    endtask

    initial begin
        logic [31:0] st;
        int e, hb, vb, lp, pl, dv, base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd7, st);
        chk("R1 status", st, 0);
        chk("R1 video", video, 0);
        chk("R1 strobe", stb, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma", dma, 0);

        // R5 disabled: page sync ignored
        set_geom(2, 1, 8, 4, 1, 32'h0);
        base = cap_n;
        psync = 1'b1; repeat (4) @(negedge vclk); psync = 1'b0;
        repeat (200) @(negedge vclk);
        chk("R5 no page while disabled", cap_n - base, 0);

        // R3 interrupt level, R2 full flag and overrun
        wr(3'd1, 32'h3);
        chk("R3 irq when empty", irq, 1);
        chk("R3 dma off in irq mode", dma, 0);
        words[0] = 32'hA5C3_0F81; nw = 1;
        wr(3'd0, words[0]);
        rd(3'd7, st);
        chk("R2 full after write", st, 32'h1);
        chk("R3 irq drops when full", irq, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd7, st);
        chk("R2 overrun set", st, 32'h5);
        rd(3'd0, st);
        chk("R2 held word kept", st, words[0]);
        run_page("overrun", 0, 0, 8, 4, 1, 1, 1, e);
        wr(3'd7, 32'h4);
        rd(3'd7, st);
        chk("R2 overrun cleared by W1C", st, 0);

        // R3 DMA mode
        wr(3'd1, 32'h7);
        chk("R3 dma when empty", dma, 1);
        chk("R3 irq off in dma mode", irq, 0);
        words[0] = 32'h8000_0001; nw = 1;
        wr(3'd0, words[0]);
        chk("R3 dma drops when full", dma, 0);
        run_page("dma", 1, 0, 8, 4, 0, 1, 1, e);

        // R8 underrun: no data supplied
        nw = 0;
        run_page("underrun", 2, 1, 16, 4, 1, 0, 0, e);
        rd(3'd7, st);
        chk("R8 underrun sticky", st, 32'h2);
        wr(3'd7, 32'h2);
        rd(3'd7, st);
        chk("R8 underrun cleared by W1C", st, 0);

        // directed: zero margins, divider 0
        nw = 2; words[0] = 32'hDEAD_BEEF; words[1] = 32'h0123_4567;
        run_page("no margins", 0, 0, 16, 4, 0, 1, 0, e);

        // random pages, asynchronous shift clock
        for (int p = 0; p < 5; p++) begin
            hb = $urandom_range(0, 5); vb = $urandom_range(0, 3);
            lp = 8 * $urandom_range(1, 5); pl = ($urandom_range(0, 1) != 0) ? 8 : 4;
            dv = $urandom_range(0, 3);
            nw = (lp * pl) / 32;
            for (int w = 0; w < nw; w++) words[w] = $urandom;
            run_page("random", hb, vb, lp, pl, dv, 1, 0, e);
            rd(3'd7, st);
            chk("R8 no underrun when fed", st[1], 0);
        end

        // R9 shift clock tied to system clock
        repeat (10) @(negedge clk);
        tie = 1'b1;
        repeat (10) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            hb = $urandom_range(0, 4); vb = $urandom_range(0, 2);
            lp = 8 * $urandom_range(1, 4); pl = 4;
            dv = $urandom_range(1, 3);
            nw = (lp * pl) / 32;
            for (int w = 0; w < nw; w++) words[w] = $urandom;
            run_page("tied", hb, vb, lp, pl, dv, 1, 0, e);
            chk("R9 tied-clock page errors", e, 0);
        end

        summary();
        $finish;
    end
endmodule